// File: doc/BRIEF.md
# Two-Mode Wireless MAC Sequencer

This block decides, cycle by cycle, whether the local wireless interface of a hybrid mesh network may drive the shared radio channel. The interfaces form a logical ring and take turns holding a token. While a node holds it, the node is the only transmitter and sends packets point to point to one destination. Every token epoch is followed by a short broadcast phase in which all interfaces exchange congestion information at once. During that phase the router crossbar must not grant any output port.

Each node runs its own copy of the sequencer. All copies watch the same channel events, so they agree on which node holds the token. An epoch ends when a fixed number of data cycles has passed or when a flit quota has crossed the channel, whichever comes first. The sequencer then raises a mode flag for the number of control cycles the broadcast needs. That count is derived at elaboration from the node count, the control message size, the clock rate and the aggregate channel rate. The packet datapath and the radio are outside the block and are seen only as pulses.

Top module: `wmac_mode_seq`

## Requirements
- R1: After reset the block is in data mode, `done` and `hold` are low, `tok_pass` is low, node 0 holds the token, and `grant` is high exactly when `node_id` is 0.
- R2: `grant` is high only in data mode, only while the tracked holder equals `node_id`, and only until a `pkt_done` pulse is seen in that epoch. After that it stays low for the rest of the epoch.
- R3: A data epoch lasts at most EPOCH_CYCLES = TOKEN_PERIOD/NUM_NODES cycles (8 by default). It runs that full length when fewer than the quota of flits are sent, including when the holder sends nothing.
- R4: A data epoch ends early in the cycle that carries the FLIT_QUOTA-th `flit_sent` pulse of the epoch. FLIT_QUOTA = PKT_FLITS*PKTS_PER_EPOCH, which is 4 by default.
- R5: In the cycle after an epoch ends, `done` and `hold` rise together. They stay high for exactly CTRL_LEN = ceil(NUM_NODES*CTRL_MSG_BITS*CLK_MHZ/(AGG_GBPS*1000)) cycles, at least 1 (3 by default), and then fall as data mode resumes.
- R6: `tok_pass` is a one-cycle pulse in the first control cycle. It is produced only when the local node held the token in the epoch that ended. `pass_idx` then equals (holder+1) mod NUM_NODES, so node 15 passes to 0.
- R7: Each epoch end moves the tracked holder one place along the ring. The new holder's epoch starts in the first data cycle after control mode.
- R8: `flit_sent` pulses during control mode are not counted toward the next epoch's quota.
- R9: A `tok_rx` pulse during control mode makes the local node the holder for the next epoch. A `tok_rx` pulse in data mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | IDX_W | Ring index of this interface |
| tok_rx | input | 1 | Token packet received by this interface |
| flit_sent | input | 1 | One flit crossed the channel this cycle |
| pkt_done | input | 1 | Local datapath has nothing more to send this epoch |
| grant | output | 1 | Local interface may transmit data |
| tok_pass | output | 1 | One-cycle token hand-off pulse |
| pass_idx | output | IDX_W | Ring index the token is handed to |
| done | output | 1 | High during control (broadcast) mode |
| hold | output | 1 | Blocks crossbar output grants during control mode |

## Verification
A wrong counter value in this block shows up as a `done` edge in the wrong cycle. That error is visible at the latest at the end of the current epoch, so within EPOCH_CYCLES + CTRL_LEN cycles. A wrong holder index shows up as `grant` on the wrong node or as a wrong `pass_idx` at the next hand-off. The stimulus table is built so that each such fault moves `grant` or `done` within one epoch. Examples are a flit counted in control mode, a token-received flag honoured in data mode, and an idle flag that is not cleared.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

   typedef enum logic {
      MODE_DATA = 1'b0,
      MODE_CTRL = 1'b1
   } wmac_mode_e;

   // Broadcast phase length in clock cycles, rounded up, never below one.
   function automatic int ctrl_cycles(input int nodes, input int msg_bits,
                                      input int clk_mhz, input int agg_gbps);
      int num;
      int den;
      int q;
      num = nodes * msg_bits * clk_mhz;
      den = agg_gbps * 1000;
      q   = (num + den - 1) / den;
      return (q < 1) ? 1 : q;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wmac_epoch_timer.sv
module wmac_epoch_timer
   import wmac_pkg::*;
#(
   parameter int EPOCH_CYCLES = 8,
   parameter int CTRL_LEN     = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  wmac_mode_e mode,
   input  logic       restart,
   output logic       data_expire,
   output logic       ctrl_expire
);

   localparam int MAX_CNT = max2(EPOCH_CYCLES, CTRL_LEN);
   localparam int CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);
   localparam logic [CNT_W-1:0] EPOCH_LAST = CNT_W'(EPOCH_CYCLES - 1);
   localparam logic [CNT_W-1:0] CTRL_LAST  = CNT_W'(CTRL_LEN - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      data_expire = (mode == MODE_DATA) && (cnt_q == EPOCH_LAST);
      ctrl_expire = (mode == MODE_CTRL) && (cnt_q == CTRL_LAST);
   end

endmodule

// File: rtl/wmac_flit_meter.sv
module wmac_flit_meter #(
   parameter int FLIT_QUOTA = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic count_en,
   input  logic mark_idle,
   input  logic clear,
   output logic quota_hit,
   output logic idle
);

   logic idle_q;

   generate
      if (FLIT_QUOTA == 1) begin : g_single
         assign quota_hit = count_en;
      end else begin : g_counter
         localparam int FW = $clog2(FLIT_QUOTA);
         localparam logic [FW-1:0] LAST = FW'(FLIT_QUOTA - 1);
         logic [FW-1:0] fcnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fcnt_q <= '0;
            end else if (clear) begin
               fcnt_q <= '0;
            end else if (count_en) begin
               fcnt_q <= fcnt_q + 1'b1;
            end
         end

         assign quota_hit = count_en && (fcnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= 1'b0;
      end else if (clear) begin
         idle_q <= 1'b0;
      end else if (mark_idle) begin
         idle_q <= 1'b1;
      end
   end

   assign idle = idle_q;

endmodule

// File: rtl/wmac_ring_tracker.sv
module wmac_ring_tracker #(
   parameter int NUM_NODES = 16,
   parameter int IDX_W     = $clog2(NUM_NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             resync,
   input  logic [IDX_W-1:0] node_id,
   output logic [IDX_W-1:0] holder,
   output logic [IDX_W-1:0] next_idx
);

   logic [IDX_W-1:0] holder_q;

   generate
      if ((1 << IDX_W) == NUM_NODES) begin : g_pow2_wrap
         assign next_idx = holder_q + 1'b1;
      end else begin : g_cmp_wrap
         localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_NODES - 1);
         assign next_idx = (holder_q == LAST_IDX) ? '0 : holder_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         holder_q <= '0;
      end else if (advance) begin
         holder_q <= next_idx;
      end else if (resync) begin
         holder_q <= node_id;
      end
   end

   assign holder = holder_q;

endmodule

// File: rtl/wmac_mode_seq.sv
module wmac_mode_seq
   import wmac_pkg::*;
#(
   parameter int NUM_NODES      = 16,
   parameter int TOKEN_PERIOD   = 128,
   parameter int PKT_FLITS      = 2,
   parameter int PKTS_PER_EPOCH = 2,
   parameter int CTRL_MSG_BITS  = 6,
   parameter int CLK_MHZ        = 1000,
   parameter int AGG_GBPS       = 32,
   localparam int IDX_W         = (NUM_NODES < 2) ? 1 : $clog2(NUM_NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] node_id,
   input  logic             tok_rx,
   input  logic             flit_sent,
   input  logic             pkt_done,
   output logic             grant,
   output logic             tok_pass,
   output logic [IDX_W-1:0] pass_idx,
   output logic             done,
   output logic             hold
);

   localparam int EPOCH_CYCLES = TOKEN_PERIOD / NUM_NODES;
   localparam int FLIT_QUOTA   = PKT_FLITS * PKTS_PER_EPOCH;
   localparam int CTRL_LEN     = ctrl_cycles(NUM_NODES, CTRL_MSG_BITS, CLK_MHZ, AGG_GBPS);

   generate
      if (NUM_NODES < 2) begin : g_bad_nodes
         $error("wmac_mode_seq: NUM_NODES must be at least 2");
      end
      if ((TOKEN_PERIOD % NUM_NODES) != 0 || EPOCH_CYCLES < 1) begin : g_bad_period
         $error("wmac_mode_seq: TOKEN_PERIOD must be a positive multiple of NUM_NODES");
      end
      if (PKT_FLITS < 1 || PKTS_PER_EPOCH < 1) begin : g_bad_quota
         $error("wmac_mode_seq: packet length and packets per epoch must be positive");
      end
      if (AGG_GBPS < 1 || CTRL_MSG_BITS < 1 || CLK_MHZ < 1) begin : g_bad_rate
         $error("wmac_mode_seq: rate and message parameters must be positive");
      end
   endgenerate

   wmac_mode_e       mode_q;
   logic             data_expire;
   logic             ctrl_expire;
   logic             quota_hit;
   logic             idle;
   logic             epoch_end;
   logic             restart;
   logic             local_hold;
   logic [IDX_W-1:0] holder;
   logic [IDX_W-1:0] next_idx;
   logic             pass_q;
   logic [IDX_W-1:0] pass_idx_q;

   assign local_hold = (holder == node_id);
   assign epoch_end  = (mode_q == MODE_DATA) && (data_expire || quota_hit);
   assign restart    = epoch_end || ctrl_expire;

   wmac_epoch_timer #(
      .EPOCH_CYCLES (EPOCH_CYCLES),
      .CTRL_LEN     (CTRL_LEN)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode_q),
      .restart     (restart),
      .data_expire (data_expire),
      .ctrl_expire (ctrl_expire)
   );

   wmac_flit_meter #(
      .FLIT_QUOTA (FLIT_QUOTA)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_en  (flit_sent && (mode_q == MODE_DATA)),
      .mark_idle (pkt_done && grant),
      .clear     (epoch_end),
      .quota_hit (quota_hit),
      .idle      (idle)
   );

   wmac_ring_tracker #(
      .NUM_NODES (NUM_NODES),
      .IDX_W     (IDX_W)
   ) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (epoch_end),
      .resync   (tok_rx && (mode_q == MODE_CTRL)),
      .node_id  (node_id),
      .holder   (holder),
      .next_idx (next_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_DATA;
      end else begin
         unique case (mode_q)
            MODE_DATA: if (epoch_end)   mode_q <= MODE_CTRL;
            MODE_CTRL: if (ctrl_expire) mode_q <= MODE_DATA;
            default:                    mode_q <= MODE_DATA;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pass_q     <= 1'b0;
         pass_idx_q <= '0;
      end else begin
         pass_q <= epoch_end && local_hold;
         if (epoch_end && local_hold) begin
            pass_idx_q <= next_idx;
         end
      end
   end

   assign grant    = (mode_q == MODE_DATA) && local_hold && !idle;
   assign tok_pass = pass_q;
   assign pass_idx = pass_idx_q;
   assign done     = (mode_q == MODE_CTRL);
   assign hold     = (mode_q == MODE_CTRL);

endmodule

// File: rtl/wmac_mode_seq_chk.sv
module wmac_mode_seq_chk #(
   parameter int EPOCH_CYCLES = 8,
   parameter int CTRL_LEN     = 3
) (
   input logic clk,
   input logic rst_n,
   input logic grant,
   input logic tok_pass,
   input logic done,
   input logic hold
);

   logic [15:0] data_run;
   logic [15:0] ctrl_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_run <= '0;
         ctrl_run <= '0;
      end else begin
         data_run <= done ? 16'd0 : data_run + 16'd1;
         ctrl_run <= done ? ctrl_run + 16'd1 : 16'd0;
      end
   end

   a_r3_epoch_bound: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (data_run < 16'(EPOCH_CYCLES)));

   a_r5_ctrl_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctrl_run < 16'(CTRL_LEN)));

   a_r5_ctrl_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> ($past(ctrl_run) == 16'(CTRL_LEN - 1)));

   a_r5_hold_tracks_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $rose(hold));

   a_r2_no_grant_in_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> !hold);

   a_r6_pass_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      tok_pass |-> $rose(done));

   a_r6_pass_single: assert property (@(posedge clk) disable iff (!rst_n)
      tok_pass |=> !tok_pass);

endmodule

bind wmac_mode_seq wmac_mode_seq_chk #(
   .EPOCH_CYCLES (EPOCH_CYCLES),
   .CTRL_LEN     (CTRL_LEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grant    (grant),
   .tok_pass (tok_pass),
   .done     (done),
   .hold     (hold)
);

// File: tb/wmac_mode_seq_tb.sv
module wmac_mode_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 38;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] node_id;
   logic       tok_rx;
   logic       flit_sent;
   logic       pkt_done;
   logic       grant;
   logic       tok_pass;
   logic [3:0] pass_idx;
   logic       done;
   logic       hold;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wmac_mode_seq dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .node_id   (node_id),
      .tok_rx    (tok_rx),
      .flit_sent (flit_sent),
      .pkt_done  (pkt_done),
      .grant     (grant),
      .tok_pass  (tok_pass),
      .pass_idx  (pass_idx),
      .done      (done),
      .hold      (hold)
   );

   // {tok_rx, flit_sent, pkt_done, exp_grant, exp_pass, exp_idx[3:0], exp_done}
   // node_id = 1 for the whole table; each entry is one clock cycle.
   localparam logic [9:0] VEC [0:NVEC-1] = '{
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c0  holder 0, remote epoch
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b0},  // c1
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b0},  // c2
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b0},  // c3
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b0},  // c4  R4 fourth flit ends epoch
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c5  R5 ctrl, no local pass (R6)
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c6
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c7
      {3'b010, 1'b1, 1'b0, 4'd0, 1'b0},  // c8  R7 holder 1 = local
      {3'b011, 1'b1, 1'b0, 4'd0, 1'b0},  // c9  pkt_done
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c10 R2 grant dropped
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c11 R3 idle epoch continues
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c12
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c13
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c14
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c15 eighth cycle
      {3'b010, 1'b0, 1'b1, 4'd2, 1'b1},  // c16 R6 pass to 2; R8 flit ignored
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b1},  // c17 R8 flit ignored
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c18
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b0},  // c19 holder 2
      {3'b110, 1'b0, 1'b0, 4'd0, 1'b0},  // c20 R9 tok_rx in data ignored
      {3'b010, 1'b0, 1'b0, 4'd0, 1'b0},  // c21 third flit only
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c22
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c23
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c24
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c25
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0},  // c26
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c27 ctrl
      {3'b100, 1'b0, 1'b0, 4'd0, 1'b1},  // c28 R9 tok_rx in ctrl
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c29
      {3'b010, 1'b1, 1'b0, 4'd0, 1'b0},  // c30 local again, not holder 3
      {3'b010, 1'b1, 1'b0, 4'd0, 1'b0},  // c31
      {3'b010, 1'b1, 1'b0, 4'd0, 1'b0},  // c32
      {3'b010, 1'b1, 1'b0, 4'd0, 1'b0},  // c33 quota hit
      {3'b000, 1'b0, 1'b1, 4'd2, 1'b1},  // c34 pass to 2
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c35
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b1},  // c36
      {3'b000, 1'b0, 1'b0, 4'd0, 1'b0}   // c37 holder 2, grant low
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
      end
   endtask

   task automatic step(input logic t, input logic f, input logic p);
      @(negedge clk);
      tok_rx    = t;
      flit_sent = f;
      pkt_done  = p;
      #1;
   endtask

   task automatic do_reset(input logic [3:0] id);
      @(negedge clk);
      rst_n     = 1'b0;
      node_id   = id;
      tok_rx    = 1'b0;
      flit_sent = 1'b0;
      pkt_done  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n     = 1'b0;
      node_id   = 4'd1;
      tok_rx    = 1'b0;
      flit_sent = 1'b0;
      pkt_done  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 with node_id = 1.
      for (int i = 0; i < NVEC; i++) begin
         tok_rx    = VEC[i][9];
         flit_sent = VEC[i][8];
         pkt_done  = VEC[i][7];
         #1;
         chk("R2", $sformatf("grant c%0d", i), int'(grant), int'(VEC[i][6]));
         chk("R6", $sformatf("tok_pass c%0d", i), int'(tok_pass), int'(VEC[i][5]));
         if (VEC[i][5]) chk("R6", $sformatf("pass_idx c%0d", i), int'(pass_idx), int'(VEC[i][4:1]));
         chk("R5", $sformatf("done c%0d", i), int'(done), int'(VEC[i][0]));
         chk("R5", $sformatf("hold c%0d", i), int'(hold), int'(VEC[i][0]));
         @(negedge clk);
      end

      // R1: reset state with node 0 as local holder.
      do_reset(4'd0);
      #1;
      chk("R1", "grant after reset", int'(grant), 1);
      chk("R1", "done after reset", int'(done), 0);
      chk("R1", "hold after reset", int'(hold), 0);
      chk("R1", "tok_pass after reset", int'(tok_pass), 0);
      // R3: idle holder keeps the channel for the full eight cycles.
      for (int c = 1; c < 8; c++) begin
         step(1'b0, 1'b0, 1'b0);
         chk("R3", $sformatf("grant held c%0d", c), int'(grant), 1);
         chk("R3", $sformatf("done low c%0d", c), int'(done), 0);
      end
      // c8: pass to node 1; now act as node 15 and receive the token (R9).
      @(negedge clk);
      node_id = 4'd15;
      tok_rx  = 1'b1;
      #1;
      chk("R6", "pass from node 0", int'(tok_pass), 1);
      chk("R6", "pass_idx from node 0", int'(pass_idx), 1);
      chk("R5", "done after idle epoch", int'(done), 1);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk("R5", "done third ctrl cycle", int'(done), 1);
      for (int c = 11; c < 19; c++) begin
         step(1'b0, 1'b0, 1'b0);
         chk("R9", $sformatf("node 15 grant c%0d", c), int'(grant), 1);
      end
      step(1'b0, 1'b0, 1'b0);
      chk("R6", "wrap pass pulse", int'(tok_pass), 1);
      chk("R6", "wrap pass_idx 15 to 0", int'(pass_idx), 0);
      chk("R2", "no grant in ctrl after wrap", int'(grant), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule